// File: doc/BRIEF.md
# Program-Cycle Status Readback

This block forms the read-data path of a byte-wide nonvolatile array that runs self-timed program cycles. While no cycle is in progress, a read returns the array word at the addressed location. While the device is busy, it returns a status word instead. That happens both during a real sector program and during the write timer that an unprotected write attempt starts. In the status word, the top bit is the inverse of the top bit of the byte loaded last. The bit below it changes value once per completed read access. The six low bits repeat the last loaded byte.

Software polls this word to see when the internal cycle has finished, so no separate status pin is needed. Either check works: compare the top bit with the value it wrote, or read twice and look for the changing bit. The bus is driven only while chip select and output enable are low and write enable is high. At all other times the outputs are high impedance.

A small controller has three states: `ST_IDLE`, `ST_BUSY` and `ST_POLL`. It tracks the busy period and the read accesses within it. `ST_IDLE` moves to `ST_POLL` when busy rises with a read active, and to `ST_BUSY` when busy rises without one. `ST_BUSY` moves to `ST_POLL` when a read starts. `ST_POLL` moves to `ST_BUSY` when a read ends, and that is the step that inverts the toggle bit. Both `ST_BUSY` and `ST_POLL` return to `ST_IDLE` when busy falls. Entering from `ST_IDLE` clears the toggle bit to 0.

Top module: `pgm_status_readback`

## Requirements
- R1: `bus_drive` is 1 in exactly the cycles where `chip_sel_n`=0, `out_en_n`=0 and `wr_en_n`=1, with no clock of delay; otherwise it is 0 (bus high impedance).
- R2: While `busy`=0, `bus_data` equals `array_rdata` in the same cycle.
- R3: While `busy`=1, bit 7 of `bus_data` is the inverse of bit 7 of `last_byte`.
- R4: While `busy`=1, bits 5..0 of `bus_data` equal bits 5..0 of `last_byte`.
- R5: Bit 6 of `bus_data` reads 0 from the cycle in which `busy` rises until the first read access of that busy period has ended. This also holds straight out of reset.
- R6: While `busy` stays 1, bit 6 of `bus_data` inverts once at the clock edge that ends each read access, meaning the first cycle with the read strobe inactive after one or more cycles with it active. It stays constant however many cycles a single access lasts, and in the gaps between accesses.
- R7: In the first cycle with `busy`=0, all eight bits of `bus_data` are true array data, even when a read access spans the fall of `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_sel_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| busy | input | 1 | Internal program or write-timer cycle running |
| last_byte | input | 8 | Byte most recently loaded for programming |
| array_rdata | input | 8 | Array word at the current address |
| bus_data | output | 8 | Value presented on the data bus |
| bus_drive | output | 1 | Output enable for the bus tri-state buffers |

## Verification
Every result is due in the same cycle as its cause except the toggle bit. The output enable, the array pass-through and the inverted and copied status bits all follow the inputs combinationally. The toggle bit takes its new value only in the cycle after the one that ended a read access. The bench applies inputs on the falling edge and checks one nanosecond later, against a reference model that advances on each rising edge. So each comparison sees the register state left by the previous edge together with the current inputs. The bound assertions cover the one-cycle toggle delay by reaching two cycles into the past, and they wait for that much history after reset before they apply.

// File: rtl/pgm_status_pkg.sv
package pgm_status_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_POLL = 2'd2
    } poll_state_t;

endpackage

// File: rtl/pgm_status_fsm.sv
module pgm_status_fsm
    import pgm_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_act,
    output logic tog_shown
);

    poll_state_t st_q, st_d;
    logic        tog_q, tog_d;

    always_comb begin
        st_d  = st_q;
        tog_d = tog_q;
        unique case (st_q)
            ST_IDLE: begin
                if (busy) begin
                    tog_d = 1'b0;
                    st_d  = rd_act ? ST_POLL : ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (!busy)
                    st_d = ST_IDLE;
                else if (rd_act)
                    st_d = ST_POLL;
            end
            ST_POLL: begin
                if (!busy) begin
                    st_d = ST_IDLE;
                end else if (!rd_act) begin
                    tog_d = ~tog_q;
                    st_d  = ST_BUSY;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            tog_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            tog_q <= tog_d;
        end
    end

    always_comb begin
        tog_shown = (st_q == ST_IDLE) ? 1'b0 : tog_q;
    end

endmodule

// File: rtl/pgm_status_mux.sv
module pgm_status_mux #(
    parameter int DATA_W = 8
) (
    input  logic              busy,
    input  logic              tog_shown,
    input  logic [DATA_W-1:0] last_byte,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] bus_data
);

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    logic [DATA_W-1:0] status_word;

    for (genvar i = 0; i < DATA_W; i++) begin : g_status
        if (i == POLL_BIT) begin : g_poll
            assign status_word[i] = ~last_byte[i];
        end else if (i == TOG_BIT) begin : g_tog
            assign status_word[i] = tog_shown;
        end else begin : g_copy
            assign status_word[i] = last_byte[i];
        end
    end

    always_comb begin
        bus_data = busy ? status_word : array_rdata;
    end

endmodule

// File: rtl/pgm_status_readback.sv
module pgm_status_readback #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              out_en_n,
    input  logic              wr_en_n,
    input  logic              busy,
    input  logic [DATA_W-1:0] last_byte,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_drive
);

    logic rd_act;
    logic tog_shown;

    assign rd_act    = ~chip_sel_n & ~out_en_n & wr_en_n;
    assign bus_drive = rd_act;

    pgm_status_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .rd_act    (rd_act),
        .tog_shown (tog_shown)
    );

    pgm_status_mux #(.DATA_W(DATA_W)) u_mux (
        .busy        (busy),
        .tog_shown   (tog_shown),
        .last_byte   (last_byte),
        .array_rdata (array_rdata),
        .bus_data    (bus_data)
    );

endmodule

// File: rtl/pgm_status_readback_chk.sv
module pgm_status_readback_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_sel_n,
    input logic              out_en_n,
    input logic              wr_en_n,
    input logic              busy,
    input logic [DATA_W-1:0] last_byte,
    input logic [DATA_W-1:0] array_rdata,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_drive
);

    logic [1:0] hist;
    logic       rd;

    assign rd = ~chip_sel_n & ~out_en_n & wr_en_n;

    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= 2'd0;
        else if (hist != 2'd3)
            hist <= hist + 2'd1;
    end

    p_drive_only_on_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> (!chip_sel_n && !out_en_n && wr_en_n));

    p_hiz_otherwise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel_n || out_en_n || !wr_en_n) |-> !bus_drive);

    p_idle_true_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_data == array_rdata));

    p_poll_inverted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bus_data[DATA_W-1] != last_byte[DATA_W-1]));

    p_low_bits_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bus_data[DATA_W-3:0] == last_byte[DATA_W-3:0]));

    p_toggle_starts_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hist != 2'd0 && busy && !$past(busy)) |-> !bus_data[DATA_W-2]);

    p_toggle_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hist != 2'd0 && busy && $past(busy) && rd && $past(rd))
            |-> (bus_data[DATA_W-2] == $past(bus_data[DATA_W-2])));

    p_toggle_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hist == 2'd3 && busy && $past(busy) && $past(busy, 2) && $past(rd, 2) && !$past(rd))
            |-> (bus_data[DATA_W-2] != $past(bus_data[DATA_W-2])));

    p_true_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hist != 2'd0 && $past(busy) && !busy) |-> (bus_data == array_rdata));

endmodule

bind pgm_status_readback pgm_status_readback_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_sel_n  (chip_sel_n),
    .out_en_n    (out_en_n),
    .wr_en_n     (wr_en_n),
    .busy        (busy),
    .last_byte   (last_byte),
    .array_rdata (array_rdata),
    .bus_data    (bus_data),
    .bus_drive   (bus_drive)
);

// File: tb/pgm_status_readback_test.sv
`timescale 1ns/1ps
module pgm_status_readback_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_sel_n = 1'b1;
    logic       out_en_n = 1'b1;
    logic       wr_en_n = 1'b1;
    logic       busy = 1'b0;
    logic [7:0] last_byte = 8'h00;
    logic [7:0] array_rdata = 8'h00;
    logic [7:0] bus_data;
    logic       bus_drive;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    bit m_in_cycle = 0;
    bit m_tog = 0;
    bit m_was_rd = 0;
    int m_reads = 0;
    bit prev_busy = 0;

    always #2 clk = ~clk;

    pgm_status_readback uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .chip_sel_n  (chip_sel_n),
        .out_en_n    (out_en_n),
        .wr_en_n     (wr_en_n),
        .busy        (busy),
        .last_byte   (last_byte),
        .array_rdata (array_rdata),
        .bus_data    (bus_data),
        .bus_drive   (bus_drive)
    );

    function automatic bit is_rd();
        return !chip_sel_n && !out_en_n && wr_en_n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_in_cycle = 0; m_tog = 0; m_was_rd = 0; m_reads = 0;
        end else if (!busy) begin
            m_in_cycle = 0; m_was_rd = 0;
        end else if (!m_in_cycle) begin
            m_in_cycle = 1; m_tog = 0; m_reads = 0; m_was_rd = is_rd();
        end else begin
            if (m_was_rd && !is_rd()) begin
                m_tog = ~m_tog;
                m_reads++;
            end
            m_was_rd = is_rd();
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit cs, input bit oe, input bit we, input bit b,
                        input logic [7:0] lb, input logic [7:0] ad);
        bit tog_exp;
        @(negedge clk);
        chip_sel_n = cs; out_en_n = oe; wr_en_n = we;
        busy = b; last_byte = lb; array_rdata = ad;
        #1;
        chk("R1", {7'd0, bus_drive}, {7'd0, (!cs && !oe && we)});
        if (b) begin
            tog_exp = m_in_cycle ? m_tog : 1'b0;
            chk("R3", {7'd0, bus_data[7]}, {7'd0, ~lb[7]});
            chk("R4", {2'd0, bus_data[5:0]}, {2'd0, lb[5:0]});
            if (!m_in_cycle || m_reads == 0)
                chk("R5", {7'd0, bus_data[6]}, {7'd0, tog_exp});
            else
                chk("R6", {7'd0, bus_data[6]}, {7'd0, tog_exp});
        end else if (prev_busy) begin
            chk("R7", bus_data, ad);
        end else begin
            chk("R2", bus_data, ad);
        end
        prev_busy = b;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // reset: busy read must show toggle 0 (R5), no read -> high impedance (R1)
        step(1, 1, 1, 1, 8'h55, 8'h00);
        step(0, 0, 1, 1, 8'h55, 8'h00);
        step(0, 0, 1, 1, 8'h55, 8'h00);
        rst_n = 1'b1;
        step(1, 1, 1, 0, 8'h00, 8'h11);

        // idle reads and non-read strobe combinations (R1, R2)
        for (int i = 0; i < 8; i++) begin
            step(0, 0, 1, 0, 8'h00, 8'(i * 37 + 5));
            step(i[0], ~i[0], i[1], 0, 8'h00, 8'(i * 91 + 3));
        end
        step(0, 0, 0, 0, 8'h00, 8'hC3);

        // busy period A: reads of varying length and gaps (R3..R6)
        for (int k = 0; k < 6; k++) begin
            for (int h = 0; h < (k % 3) + 1; h++)
                step(0, 0, 1, 1, 8'hA5, 8'(k));
            for (int g = 0; g < (k % 2) + 1; g++)
                step(g[0], 1, k[0], 1, 8'hA5, 8'(k));
        end
        // busy falls during a read (R7), then idle
        step(0, 0, 1, 1, 8'hA5, 8'h5A);
        step(0, 0, 1, 0, 8'hA5, 8'h5A);
        step(0, 0, 1, 0, 8'hA5, 8'h5A);
        step(1, 1, 1, 0, 8'hA5, 8'h77);

        // busy period B: busy rises with a read already active (R5)
        step(0, 0, 1, 1, 8'h3C, 8'h00);
        step(0, 0, 1, 1, 8'h3C, 8'h00);
        step(1, 0, 1, 1, 8'h3C, 8'h00);
        step(0, 0, 1, 1, 8'h3C, 8'h00);
        step(0, 1, 1, 1, 8'h3C, 8'h00);
        step(0, 1, 1, 0, 8'h3C, 8'hE1);
        step(0, 0, 1, 0, 8'h3C, 8'hE1);

        // busy period C: single-cycle reads back to back, write-timer style (R6)
        for (int j = 0; j < 12; j++)
            step(j[0], j[0], 1, 1, 8'h80, 8'hFF);
        step(1, 1, 1, 0, 8'h80, 8'h0F);
        step(0, 0, 1, 0, 8'h80, 8'hF0);

        finish_run();
    end

endmodule